// File: doc/BRIEF.md
# Register-programmed signal crossbar switch

This block routes single-bit signals between on-chip functions through an array of output multiplexers. Every output multiplexer sees the same ordered vector of inputs. Each output has its own select field, and the value held in that field is the index of the input that drives the output. One input may feed many outputs at the same time, so a single trigger source can be sent to several consumers.

The data path holds no register. An output follows its selected input combinationally and changes only when that input changes or when its select field is rewritten. Software programs the routing through a small word-wide register bank in which two select fields share each 16-bit register. Register k holds the field for output 2k in bits 5:0 and the field for output 2k+1 in bits 13:8. The number of inputs and the number of outputs are both parameters. The default build has 32 inputs and 41 outputs.

Top module: `sigroute_xbar`

## Requirements
- R1: After reset every select field is zero, every register reads 0x0000, and every output follows input 0.
- R2: When an output's select field holds a value s below the input count, that output equals input s. It follows changes on input s with no clock edge in between.
- R3: A write to register k in the cycle that `bus_we` is high stores bits 5:0 as the field of output 2k and bits 13:8 as the field of output 2k+1, starting from the next clock edge. Bits 7:6 and 15:14 are discarded and always read as zero.
- R4: When an output's select field holds a value greater than or equal to the input count, that output is driven low.
- R5: One input may be selected by several outputs at once, and each of those outputs then carries that input's value.
- R6: A write to register k changes no field held in any other register, and so changes no output other than 2k and 2k+1.
- R7: `bus_rdata` returns, with no clock edge needed, the packed fields of the register at `bus_addr`. An address at or above the register count reads 0x0000, and a write to such an address changes nothing.
- R8: When the output count is odd, bits 13:8 of the last register have no output behind them. They read as zero and ignore writes.
- R9: While `bus_we` is low, no select field changes, whatever `bus_addr` and `bus_wdata` carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the select register bank |
| rst | input | 1 | Asynchronous reset, active high; clears all select fields |
| sig_in | input | NUM_IN | Shared input vector seen by every output multiplexer |
| sig_out | output | NUM_OUT | Routed outputs, one per multiplexer |
| bus_we | input | 1 | Write strobe for the register at bus_addr |
| bus_addr | input | ADDR_W | Register index; ADDR_W is $clog2(ceil(NUM_OUT/2)+1) |
| bus_wdata | input | 16 | Write data: even field in bits 5:0, odd field in bits 13:8 |
| bus_rdata | output | 16 | Packed select fields of the addressed register |

## Verification
The bench builds two instances side by side.

The first uses the default 32 inputs and 41 outputs. With an odd output count, the last register has an unbacked upper half. Its address width also leaves registers 21 to 31 past the end, so writes and reads at those addresses can be exercised.

The second uses 26 inputs and 16 outputs, which is not a power of two. This makes select codes 26 to 63 reachable, and so exercises the drive-low path and the boundary at index 25. This instance also has an even output count, so every upper field is backed by an output.

// File: rtl/sigroute_pkg.sv
package sigroute_pkg;

   // Width of one select code and of one bus word.
   localparam int SEL_W    = 6;
   localparam int REG_W    = 16;
   // Bit offsets of the two select fields within a register.
   localparam int EVEN_LSB = 0;
   localparam int ODD_LSB  = 8;
   // Largest input count a select code can index.
   localparam int MAX_IN   = 2 ** SEL_W;

   // Bits of a register that hold stored select data.
   localparam logic [REG_W-1:0] FIELD_MASK =
      REG_W'(((2 ** SEL_W) - 1) << EVEN_LSB) | REG_W'(((2 ** SEL_W) - 1) << ODD_LSB);

   // Registers needed to hold the fields of m outputs, two per register.
   function automatic int reg_count(input int m);
      return (m + 1) / 2;
   endfunction

   // Address width, with room for at least one address past the last register.
   function automatic int addr_width(input int m);
      return $clog2(reg_count(m) + 1);
   endfunction

endpackage

// File: rtl/sigroute_selbank.sv
module sigroute_selbank
   import sigroute_pkg::*;
#(
   parameter int NUM_OUT = 41,
   parameter int ADDR_W  = 5
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     wr_en,
   input  logic [ADDR_W-1:0]        wr_addr,
   input  logic [REG_W-1:0]         wr_data,
   output logic [NUM_OUT*SEL_W-1:0] sel_flat
);

   // Bits of the write word that no field stores.
   logic unused_wr_bits;
   assign unused_wr_bits = ^(wr_data & ~FIELD_MASK);

   for (genvar o = 0; o < NUM_OUT; o++) begin : g_field
      localparam int RIDX = o / 2;
      localparam int LSB  = (o % 2 == 1) ? ODD_LSB : EVEN_LSB;

      logic [SEL_W-1:0] field_q;
      logic             hit;

      assign hit = wr_en && (wr_addr == RIDX[ADDR_W-1:0]);

      always_ff @(posedge clk or posedge rst) begin
         if (rst) begin
            field_q <= '0;
         end else if (hit) begin
            field_q <= wr_data[LSB +: SEL_W];
         end
      end

      assign sel_flat[o*SEL_W +: SEL_W] = field_q;
   end

endmodule

// File: rtl/sigroute_readback.sv
module sigroute_readback
   import sigroute_pkg::*;
#(
   parameter int NUM_OUT = 41,
   parameter int ADDR_W  = 5
) (
   input  logic [ADDR_W-1:0]        rd_addr,
   input  logic [NUM_OUT*SEL_W-1:0] sel_flat,
   output logic [REG_W-1:0]         rd_data
);

   localparam int NREG = reg_count(NUM_OUT);

   logic [REG_W-1:0] word [NREG];

   for (genvar k = 0; k < NREG; k++) begin : g_word
      logic [REG_W-1:0] w;
      if (2 * k + 1 < NUM_OUT) begin : g_pair
         always_comb begin
            w = '0;
            w[EVEN_LSB +: SEL_W] = sel_flat[(2*k)*SEL_W +: SEL_W];
            w[ODD_LSB  +: SEL_W] = sel_flat[(2*k+1)*SEL_W +: SEL_W];
         end
      end else begin : g_single
         always_comb begin
            w = '0;
            w[EVEN_LSB +: SEL_W] = sel_flat[(2*k)*SEL_W +: SEL_W];
         end
      end
      assign word[k] = w;
   end

   always_comb begin
      rd_data = '0;
      for (int k = 0; k < NREG; k++) begin
         if (rd_addr == ADDR_W'(k)) begin
            rd_data = word[k];
         end
      end
   end

endmodule

// File: rtl/sigroute_mux.sv
module sigroute_mux
   import sigroute_pkg::*;
#(
   parameter int NUM_IN = 32
) (
   input  logic [NUM_IN-1:0] mux_in,
   input  logic [SEL_W-1:0]  mux_sel,
   output logic              mux_out
);

   if (NUM_IN == MAX_IN) begin : g_full
      // Every code names a real input.
      assign mux_out = mux_in[mux_sel];
   end else begin : g_padded
      // Codes past the last input land on zero padding.
      logic [MAX_IN-1:0] padded;
      assign padded  = {{(MAX_IN - NUM_IN){1'b0}}, mux_in};
      assign mux_out = padded[mux_sel];
   end

endmodule

// File: rtl/sigroute_xbar.sv
module sigroute_xbar
   import sigroute_pkg::*;
#(
   parameter int NUM_IN  = 32,
   parameter int NUM_OUT = 41,
   localparam int ADDR_W = addr_width(NUM_OUT)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [NUM_IN-1:0]  sig_in,
   output logic [NUM_OUT-1:0] sig_out,
   input  logic               bus_we,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [REG_W-1:0]   bus_wdata,
   output logic [REG_W-1:0]   bus_rdata
);

   // Elaboration-time parameter checks.
   if (NUM_IN < 1 || NUM_IN > MAX_IN) begin : g_bad_in
      $error("sigroute_xbar: NUM_IN must lie in 1..%0d", MAX_IN);
   end
   if (NUM_OUT < 1) begin : g_bad_out
      $error("sigroute_xbar: NUM_OUT must be at least 1");
   end
   if (ODD_LSB < EVEN_LSB + SEL_W || ODD_LSB + SEL_W > REG_W) begin : g_bad_pack
      $error("sigroute_xbar: select fields do not fit the register word");
   end

   logic [NUM_OUT*SEL_W-1:0] sel_flat;

   sigroute_selbank #(
      .NUM_OUT (NUM_OUT),
      .ADDR_W  (ADDR_W)
   ) u_bank (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (bus_we),
      .wr_addr  (bus_addr),
      .wr_data  (bus_wdata),
      .sel_flat (sel_flat)
   );

   sigroute_readback #(
      .NUM_OUT (NUM_OUT),
      .ADDR_W  (ADDR_W)
   ) u_rdbk (
      .rd_addr  (bus_addr),
      .sel_flat (sel_flat),
      .rd_data  (bus_rdata)
   );

   for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
      sigroute_mux #(
         .NUM_IN (NUM_IN)
      ) u_mux (
         .mux_in  (sig_in),
         .mux_sel (sel_flat[o*SEL_W +: SEL_W]),
         .mux_out (sig_out[o])
      );
   end

endmodule

// File: rtl/sigroute_xbar_chk.sv
module sigroute_xbar_chk
   import sigroute_pkg::*;
#(
   parameter int NUM_IN  = 32,
   parameter int NUM_OUT = 41,
   parameter int ADDR_W  = 5
) (
   input logic                     clk,
   input logic                     rst,
   input logic [NUM_IN-1:0]        sig_in,
   input logic [NUM_OUT-1:0]       sig_out,
   input logic                     bus_we,
   input logic [ADDR_W-1:0]        bus_addr,
   input logic [REG_W-1:0]         bus_wdata,
   input logic [REG_W-1:0]         bus_rdata,
   input logic [NUM_OUT*SEL_W-1:0] sel_flat
);

   localparam int NREG = reg_count(NUM_OUT);

   logic [MAX_IN-1:0] in_ext;
   always_comb begin
      in_ext = '0;
      in_ext[NUM_IN-1:0] = sig_in;
   end

   // Track the most recent write, to compare the readback against it.
   logic              wr_ok_q;
   logic [ADDR_W-1:0] wr_addr_q;
   logic [REG_W-1:0]  wr_exp_q;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         wr_ok_q   <= 1'b0;
         wr_addr_q <= '0;
         wr_exp_q  <= '0;
      end else begin
         wr_ok_q   <= bus_we;
         wr_addr_q <= bus_addr;
         wr_exp_q  <= '0;
         if (int'(bus_addr) < NREG) begin
            wr_exp_q[EVEN_LSB +: SEL_W] <= bus_wdata[EVEN_LSB +: SEL_W];
            if (2 * int'(bus_addr) + 1 < NUM_OUT) begin
               wr_exp_q[ODD_LSB +: SEL_W] <= bus_wdata[ODD_LSB +: SEL_W];
            end
         end
      end
   end

   // R1: fields are clear in the first cycle after reset.
   p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (sel_flat == '0));

   // R3, R7 and R8: readback matches the last write, as masked.
   p_readback_r7: assert property (@(posedge clk) disable iff (rst)
      (wr_ok_q && (bus_addr == wr_addr_q)) |-> (bus_rdata == wr_exp_q));

   // R3: bits outside the two fields always read zero.
   p_spare_zero_r3: assert property (@(posedge clk) disable iff (rst)
      (bus_rdata & ~FIELD_MASK) == '0);

   // R9: no field moves without a write strobe.
   p_hold_r9: assert property (@(posedge clk) disable iff (rst)
      !bus_we |=> $stable(sel_flat));

   for (genvar o = 0; o < NUM_OUT; o++) begin : g_chk
      logic [SEL_W-1:0] s;
      assign s = sel_flat[o*SEL_W +: SEL_W];

      // R2: an in-range code routes that input.
      p_route_r2: assert property (@(posedge clk) disable iff (rst)
         (int'(s) < NUM_IN) |-> (sig_out[o] == in_ext[s]));

      // R4: an out-of-range code drives the output low.
      p_oor_low_r4: assert property (@(posedge clk) disable iff (rst)
         (int'(s) >= NUM_IN) |-> !sig_out[o]);
   end

endmodule

bind sigroute_xbar sigroute_xbar_chk #(
   .NUM_IN  (NUM_IN),
   .NUM_OUT (NUM_OUT),
   .ADDR_W  (ADDR_W)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .sig_in    (sig_in),
   .sig_out   (sig_out),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .sel_flat  (sel_flat)
);

// File: tb/sigroute_xbar_tb_top.sv
module sigroute_xbar_tb_top;
   import sigroute_pkg::*;

   localparam int A_IN  = 32;
   localparam int A_OUT = 41;
   localparam int B_IN  = 26;
   localparam int B_OUT = 16;
   localparam int A_AW  = addr_width(A_OUT);
   localparam int B_AW  = addr_width(B_OUT);

   logic clk = 1'b0;
   always #4 clk = ~clk;
   logic rst;

   logic [A_IN-1:0]  a_in;
   logic [A_OUT-1:0] a_out;
   logic             a_we;
   logic [A_AW-1:0]  a_addr;
   logic [15:0]      a_wd, a_rd;
   logic [B_IN-1:0]  b_in;
   logic [B_OUT-1:0] b_out;
   logic             b_we;
   logic [B_AW-1:0]  b_addr;
   logic [15:0]      b_wd, b_rd;

   sigroute_xbar #(.NUM_IN(A_IN), .NUM_OUT(A_OUT)) dut_i (
      .clk(clk), .rst(rst), .sig_in(a_in), .sig_out(a_out),
      .bus_we(a_we), .bus_addr(a_addr), .bus_wdata(a_wd), .bus_rdata(a_rd));

   sigroute_xbar #(.NUM_IN(B_IN), .NUM_OUT(B_OUT)) dut_b (
      .clk(clk), .rst(rst), .sig_in(b_in), .sig_out(b_out),
      .bus_we(b_we), .bus_addr(b_addr), .bus_wdata(b_wd), .bus_rdata(b_rd));

   int  model [2][64];
   int  n_chk = 0;
   int  n_bad = 0;
   bit  done  = 0;

   function automatic int n_in(int d);  return d ? B_IN : A_IN;   endfunction
   function automatic int n_out(int d); return d ? B_OUT : A_OUT; endfunction
   function automatic int n_addr(int d); return d ? (1 << B_AW) : (1 << A_AW); endfunction

   function automatic logic exp_out(int d, int o);
      int s = model[d][o];
      if (s >= n_in(d)) return 1'b0;
      return d ? b_in[s] : a_in[s];
   endfunction

   function automatic logic [15:0] exp_rd(int d, int k);
      logic [15:0] r = '0;
      if (k >= reg_count(n_out(d))) return r;
      r[5:0] = 6'(model[d][2*k]);
      if (2*k + 1 < n_out(d)) r[13:8] = 6'(model[d][2*k+1]);
      return r;
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic bus_cycle(int d, int addr, logic [15:0] data, bit we);
      @(negedge clk);
      if (d == 0) begin a_we = we; a_addr = A_AW'(addr); a_wd = data; end
      else        begin b_we = we; b_addr = B_AW'(addr); b_wd = data; end
      @(negedge clk);
      a_we = 1'b0; b_we = 1'b0;
      if (we && addr < reg_count(n_out(d))) begin
         model[d][2*addr] = int'(data[5:0]);
         if (2*addr + 1 < n_out(d)) model[d][2*addr+1] = int'(data[13:8]);
      end
   endtask

   task automatic check_outs(int d, string tag);
      #1;
      for (int o = 0; o < n_out(d); o++) begin
         check($sformatf("%s out%0d dut%0d", tag, o, d),
               32'(d ? b_out[o] : a_out[o]), 32'(exp_out(d, o)));
      end
   endtask

   task automatic check_reads(int d, string tag);
      for (int k = 0; k < n_addr(d); k++) begin
         if (d == 0) a_addr = A_AW'(k); else b_addr = B_AW'(k);
         #1;
         check($sformatf("%s reg%0d dut%0d", tag, k, d),
               32'(d ? b_rd : a_rd), 32'(exp_rd(d, k)));
      end
   endtask

   task automatic rand_inputs();
      a_in = A_IN'($urandom);
      b_in = B_IN'($urandom);
   endtask

   initial begin
      int seed_val;
      seed_val = $urandom(32'd20240611);
      for (int d = 0; d < 2; d++) for (int o = 0; o < 64; o++) model[d][o] = 0;
      rst = 1'b1; a_we = 0; b_we = 0; a_addr = '0; b_addr = '0; a_wd = '0; b_wd = '0;
      a_in = '0; b_in = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);

      // R1: reset state
      for (int p = 0; p < 3; p++) begin
         rand_inputs();
         check_outs(0, "R1"); check_outs(1, "R1");
      end
      check_reads(0, "R1"); check_reads(1, "R1");

      // R2: register 14 upper half = 7 routes input 7 to output 29
      bus_cycle(0, 14, 16'h0700, 1);
      a_in = '0; a_in[7] = 1'b1; #1;
      check("R2 out29 high", 32'(a_out[29]), 32'd1);
      a_in[7] = 1'b0; #1;
      check("R2 out29 low", 32'(a_out[29]), 32'd0);
      bus_cycle(0, 15, 16'h1C06, 1);
      for (int p = 0; p < 4; p++) begin rand_inputs(); check_outs(0, "R2"); end

      // R5: outputs 16..19 all select input 29
      bus_cycle(0, 8, 16'h1D1D, 1);
      bus_cycle(0, 9, 16'h1D1D, 1);
      a_in = A_IN'(1) << 29; #1;
      for (int o = 16; o < 20; o++) check($sformatf("R5 fanout out%0d", o), 32'(a_out[o]), 32'd1);
      a_in = ~(A_IN'(1) << 29); #1;
      for (int o = 16; o < 20; o++) check($sformatf("R5 fanout out%0d", o), 32'(a_out[o]), 32'd0);

      // R3, R4: all-ones write keeps only the fields, code 63 drives low
      bus_cycle(0, 3, 16'hFFFF, 1);
      a_in = '1;
      check_outs(0, "R4");
      a_addr = A_AW'(3); #1;
      check("R3 reg3 mask", 32'(a_rd), 32'h3F3F);

      // R4 on the 26-input build, with boundary index 25
      bus_cycle(1, 1, 16'h1919, 1);
      bus_cycle(1, 2, 16'h281A, 1);
      b_in = '1;
      check_outs(1, "R4");
      b_in = '0; b_in[25] = 1'b1; #1;
      check("R2 boundary out2", 32'(b_out[2]), 32'd1);
      check("R2 boundary out3", 32'(b_out[3]), 32'd1);

      // R8: the last register of the odd build has no upper field
      bus_cycle(0, 20, 16'h0505, 1);
      a_addr = A_AW'(20); #1;
      check("R8 reg20", 32'(a_rd), 32'h0005);
      a_in = '0; a_in[5] = 1'b1; #1;
      check("R8 out40", 32'(a_out[40]), 32'd1);

      // R7: writes past the last register change nothing
      for (int k = 21; k < 32; k++) bus_cycle(0, k, 16'h0101, 1);
      for (int k = 8; k < 16; k++) bus_cycle(1, k, 16'h0202, 1);
      check_reads(0, "R7"); check_reads(1, "R7");
      check_outs(0, "R7"); check_outs(1, "R7");

      // R9: strobe low leaves every field alone
      for (int k = 0; k < 4; k++) begin
         bus_cycle(0, k, 16'h0303, 0);
         bus_cycle(1, k, 16'h0303, 0);
      end
      check_reads(0, "R9"); check_reads(1, "R9");

      // R6 with R2 and R4: random writes, every field and output compared
      for (int it = 0; it < 250; it++) begin
         int d = it % 2;
         bus_cycle(d, $urandom_range(n_addr(d) - 1), 16'($urandom), 1);
         rand_inputs();
         check_outs(d, "R6");
         if (it % 10 == 0) check_reads(d, "R6");
      end
      check_reads(0, "R6"); check_reads(1, "R6");

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule